// File: doc/BRIEF.md
# Pattern Failure History Capture Memory

This block records the results of a pattern burst, one entry per executed cycle, into an on-chip memory so that a host can read them back later for debug and failure analysis. Each burst begins with a start pulse. The start pulse clears the cycle counter, discards the previous burst's results and arms a trigger. Recording begins on the first cycle that meets the selected trigger. The trigger can be the first failing cycle, a chosen cycle number, a chosen vector label, or the first cycle of the burst. Recording then continues on every executed cycle. It stops when the configured entry count is reached, when the depth available to one site is used up, or when the burst ends.

Several test sites share the memory, so the depth available to one site shrinks as the site count grows. The block computes the limit once, at the start pulse. Each entry holds five fields from the executed cycle: its cycle number, vector address, time-set index, label identifier and per-pin fail mask. Each entry also holds a running union of the fail masks over the consecutive recorded cycles of the same vector. For a vector that repeats over several cycles, the last entry of the run therefore carries the superset of its pin failures. The host reads entries by index, in capture order, through a request/valid port.

Top module: `hist_capture`

## Requirements
- R1: After reset, `done`, `capturing`, `rdValid` are 0 and `storedCount` is 0.
- R2: A `burstStart` pulse clears the cycle counter, sets `storedCount` to 0 and clears `done` in the next cycle. New entries are written from index 0, overwriting the previous burst.
- R3: With `trigMode` = 0, recording begins on the first valid cycle whose `failMask` is nonzero. If no cycle fails, nothing is recorded.
- R4: With `trigMode` = 1, recording begins on the valid cycle whose number equals `trigCycle`. Cycle numbers count the valid cycles since `burstStart`, and the first valid cycle is number 0.
- R5: With `trigMode` = 2, recording begins on the valid cycle whose `labelId` equals `trigLabel`. With `trigMode` = 3, recording begins on the first valid cycle.
- R6: Once recording has begun, every cycle with `cycleValid` high is stored at the next index and `storedCount` rises by exactly 1. Cycles with `cycleValid` low store nothing.
- R7: The entry limit is `cfgCount`. When `cfgCount` is 0 or larger than the site depth, the limit is the site depth instead. The site depth is (TOTAL_DEPTH >> `siteSel`) − 1, where `siteSel` 0,1,2,3 means 1,2,4,8 sites. `done` rises when `storedCount` reaches the limit, and later cycles are not stored.
- R8: A `burstEnd` pulse while the block is armed or recording sets `done`. The cycle presented with `burstEnd` is not stored.
- R9: An entry returns, unchanged, the cycle number, `vecAddr`, `tsetIdx`, `labelId` and `failMask` of the cycle it recorded.
- R10: `rdUnion` of an entry is the OR of the fail masks of that entry and of the directly preceding recorded entries of the same burst that share its `vecAddr`.
- R11: A `rdReq` with `rdAddr` < `storedCount` gives `rdValid` = 1 and the entry in the next cycle. Otherwise `rdValid` is 0 in the next cycle.
- R12: `capturing` is high from the cycle after the trigger until `done` rises. It is never high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstStart | input | 1 | Start of a burst: clear and arm |
| burstEnd | input | 1 | End of the burst |
| trigMode | input | 2 | 0 first fail, 1 cycle number, 2 label, 3 immediate |
| trigCycle | input | CYC_W | Cycle number for trigger mode 1 |
| trigLabel | input | LABEL_W | Label for trigger mode 2 |
| cfgCount | input | PTR_W | Entries to store, 0 means site depth |
| siteSel | input | 2 | log2 of the active site count |
| cycleValid | input | 1 | One executed pattern cycle this clock |
| vecAddr | input | VEC_W | Vector address of the cycle |
| tsetIdx | input | TSET_W | Time-set index of the cycle |
| labelId | input | LABEL_W | Label identifier of the cycle |
| failMask | input | PINS | Per-pin compare failures of the cycle |
| rdReq | input | 1 | Read request |
| rdAddr | input | PTR_W | Entry index to read |
| rdValid | output | 1 | Read data valid |
| rdCycle | output | CYC_W | Entry cycle number |
| rdVec | output | VEC_W | Entry vector address |
| rdTset | output | TSET_W | Entry time-set index |
| rdLabel | output | LABEL_W | Entry label |
| rdFail | output | PINS | Entry fail mask |
| rdUnion | output | PINS | Union of fail masks over the vector run |
| storedCount | output | PTR_W | Entries stored in this burst |
| done | output | 1 | Capture finished |
| capturing | output | 1 | Recording in progress |

## Verification
The assertions check the following on every cycle. A start pulse empties the store. The stored count never jumps by more than one, and it rises by exactly one for each valid cycle while recording. Once `done` is set, it holds and freezes the count. An end pulse during recording sets `done`. Read-valid only follows a request, and `capturing` and `done` never overlap.

Only the bench scenarios can show which cycle each trigger mode picks and how the per-site limit is derived from the site selection. They also show that fields come back unchanged in capture order, and that the fail-mask union grows across a repeated vector and restarts on a new one.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [1:0] {
    TRIG_FAIL  = 2'd0,
    TRIG_CYCLE = 2'd1,
    TRIG_LABEL = 2'd2,
    TRIG_NOW   = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // store the current cycle
    logic runClear;  // forget the vector run of the previous burst
  } hist_strobe_t;

endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int LABEL_W     = 8,
  parameter int CYC_W       = 32,
  parameter int TOTAL_DEPTH = 64,
  localparam int PTR_W      = $clog2(TOTAL_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               burstStart,
  input  logic               burstEnd,
  input  logic               cycleValid,
  input  logic [1:0]         trigMode,
  input  logic [CYC_W-1:0]   trigCycle,
  input  logic [LABEL_W-1:0] trigLabel,
  input  logic [PTR_W-1:0]   cfgCount,
  input  logic [1:0]         siteSel,
  input  logic [LABEL_W-1:0] labelId,
  input  logic [PINS-1:0]    failMask,
  output hist_strobe_t       strobe,
  output logic [PTR_W-1:0]   wrIdx,
  output logic [CYC_W-1:0]   cycNum,
  output logic [PTR_W-1:0]   storedCount,
  output logic               done,
  output logic               capturing
);

  localparam int SITE_OPTS = 4;

  cap_state_e       state;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] nextPtr;
  logic [PTR_W-1:0] limitQ;
  logic [CYC_W-1:0] cycCnt;
  logic [PTR_W-1:0] depthOpt [SITE_OPTS];
  logic [PTR_W-1:0] siteDepth;
  logic [PTR_W-1:0] effLimit;
  logic             trigHit;
  logic             takeCycle;

  // One depth per site-count option: shared memory split, one slot reserved
  for (genvar s = 0; s < SITE_OPTS; s++) begin : g_depth
    assign depthOpt[s] = PTR_W'((TOTAL_DEPTH >> s) - 1);
  end

  assign siteDepth = depthOpt[siteSel];
  assign effLimit  = (cfgCount == '0 || cfgCount > siteDepth) ? siteDepth : cfgCount;

  always_comb begin
    unique case (trig_mode_e'(trigMode))
      TRIG_FAIL:  trigHit = |failMask;
      TRIG_CYCLE: trigHit = (cycCnt == trigCycle);
      TRIG_LABEL: trigHit = (labelId == trigLabel);
      default:    trigHit = 1'b1;
    endcase
  end

  assign takeCycle = cycleValid && !burstStart && !burstEnd &&
                     ((state == ST_CAPT) || (state == ST_ARMED && trigHit));
  assign nextPtr   = wrPtr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wrPtr  <= '0;
      limitQ <= '0;
      cycCnt <= '0;
    end else if (burstStart) begin
      state  <= ST_ARMED;
      wrPtr  <= '0;
      limitQ <= effLimit;
      cycCnt <= '0;
    end else begin
      if (cycleValid) cycCnt <= cycCnt + 1'b1;
      if (burstEnd && (state == ST_ARMED || state == ST_CAPT)) begin
        state <= ST_DONE;
      end else if (takeCycle) begin
        wrPtr <= nextPtr;
        state <= (nextPtr == limitQ) ? ST_DONE : ST_CAPT;
      end
    end
  end

  assign strobe.wrEn     = takeCycle;
  assign strobe.runClear = burstStart;
  assign wrIdx           = wrPtr;
  assign cycNum          = cycCnt;
  assign storedCount     = wrPtr;
  assign done            = (state == ST_DONE);
  assign capturing       = (state == ST_CAPT);

endmodule

// File: rtl/hist_dp.sv
module hist_dp
  import hist_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int VEC_W       = 16,
  parameter int TSET_W      = 5,
  parameter int LABEL_W     = 8,
  parameter int CYC_W       = 32,
  parameter int TOTAL_DEPTH = 64,
  localparam int PTR_W      = $clog2(TOTAL_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  hist_strobe_t       strobe,
  input  logic [PTR_W-1:0]   wrIdx,
  input  logic [CYC_W-1:0]   cycNum,
  input  logic [VEC_W-1:0]   vecAddr,
  input  logic [TSET_W-1:0]  tsetIdx,
  input  logic [LABEL_W-1:0] labelId,
  input  logic [PINS-1:0]    failMask,
  input  logic [PTR_W-1:0]   storedCount,
  input  logic               rdReq,
  input  logic [PTR_W-1:0]   rdAddr,
  output logic               rdValid,
  output logic [CYC_W-1:0]   rdCycle,
  output logic [VEC_W-1:0]   rdVec,
  output logic [TSET_W-1:0]  rdTset,
  output logic [LABEL_W-1:0] rdLabel,
  output logic [PINS-1:0]    rdFail,
  output logic [PINS-1:0]    rdUnion
);

  typedef struct packed {
    logic [CYC_W-1:0]   cyc;
    logic [VEC_W-1:0]   vec;
    logic [TSET_W-1:0]  tset;
    logic [LABEL_W-1:0] label;
    logic [PINS-1:0]    fail;
    logic [PINS-1:0]    failAcc;
  } entry_t;

  entry_t           store [TOTAL_DEPTH];
  entry_t           wrEntry;
  entry_t           rdEntry;
  logic             haveLast;
  logic [VEC_W-1:0] lastVec;
  logic [PINS-1:0]  lastAcc;
  logic             sameRun;
  logic [PINS-1:0]  newAcc;

  assign sameRun = haveLast && (vecAddr == lastVec);
  assign newAcc  = sameRun ? (lastAcc | failMask) : failMask;

  always_comb begin
    wrEntry.cyc     = cycNum;
    wrEntry.vec     = vecAddr;
    wrEntry.tset    = tsetIdx;
    wrEntry.label   = labelId;
    wrEntry.fail    = failMask;
    wrEntry.failAcc = newAcc;
  end

  // Storage and registered read, no reset on the array
  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrIdx] <= wrEntry;
    if (rdReq)       rdEntry      <= store[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveLast <= 1'b0;
      lastVec  <= '0;
      lastAcc  <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strobe.runClear) begin
        haveLast <= 1'b0;
      end else if (strobe.wrEn) begin
        haveLast <= 1'b1;
        lastVec  <= vecAddr;
        lastAcc  <= newAcc;
      end
      rdValid <= rdReq && (rdAddr < storedCount);
    end
  end

  assign rdCycle = rdEntry.cyc;
  assign rdVec   = rdEntry.vec;
  assign rdTset  = rdEntry.tset;
  assign rdLabel = rdEntry.label;
  assign rdFail  = rdEntry.fail;
  assign rdUnion = rdEntry.failAcc;

endmodule

// File: rtl/hist_capture.sv
module hist_capture
  import hist_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int VEC_W       = 16,
  parameter int TSET_W      = 5,
  parameter int LABEL_W     = 8,
  parameter int CYC_W       = 32,
  parameter int TOTAL_DEPTH = 64,
  localparam int PTR_W      = $clog2(TOTAL_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               burstStart,
  input  logic               burstEnd,
  input  logic [1:0]         trigMode,
  input  logic [CYC_W-1:0]   trigCycle,
  input  logic [LABEL_W-1:0] trigLabel,
  input  logic [PTR_W-1:0]   cfgCount,
  input  logic [1:0]         siteSel,
  input  logic               cycleValid,
  input  logic [VEC_W-1:0]   vecAddr,
  input  logic [TSET_W-1:0]  tsetIdx,
  input  logic [LABEL_W-1:0] labelId,
  input  logic [PINS-1:0]    failMask,
  input  logic               rdReq,
  input  logic [PTR_W-1:0]   rdAddr,
  output logic               rdValid,
  output logic [CYC_W-1:0]   rdCycle,
  output logic [VEC_W-1:0]   rdVec,
  output logic [TSET_W-1:0]  rdTset,
  output logic [LABEL_W-1:0] rdLabel,
  output logic [PINS-1:0]    rdFail,
  output logic [PINS-1:0]    rdUnion,
  output logic [PTR_W-1:0]   storedCount,
  output logic               done,
  output logic               capturing
);

  hist_strobe_t     strobe;
  logic [PTR_W-1:0] wrIdx;
  logic [CYC_W-1:0] cycNum;

  hist_ctrl #(
    .PINS(PINS), .LABEL_W(LABEL_W), .CYC_W(CYC_W), .TOTAL_DEPTH(TOTAL_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .burstEnd(burstEnd),
    .cycleValid(cycleValid), .trigMode(trigMode), .trigCycle(trigCycle),
    .trigLabel(trigLabel), .cfgCount(cfgCount), .siteSel(siteSel),
    .labelId(labelId), .failMask(failMask), .strobe(strobe), .wrIdx(wrIdx),
    .cycNum(cycNum), .storedCount(storedCount), .done(done), .capturing(capturing)
  );

  hist_dp #(
    .PINS(PINS), .VEC_W(VEC_W), .TSET_W(TSET_W), .LABEL_W(LABEL_W),
    .CYC_W(CYC_W), .TOTAL_DEPTH(TOTAL_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .cycNum(cycNum),
    .vecAddr(vecAddr), .tsetIdx(tsetIdx), .labelId(labelId), .failMask(failMask),
    .storedCount(storedCount), .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdCycle(rdCycle), .rdVec(rdVec), .rdTset(rdTset), .rdLabel(rdLabel),
    .rdFail(rdFail), .rdUnion(rdUnion)
  );

endmodule

// File: rtl/hist_capture_chk.sv
module hist_capture_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             burstStart,
  input logic             burstEnd,
  input logic             cycleValid,
  input logic             rdReq,
  input logic             rdValid,
  input logic [CNT_W-1:0] storedCount,
  input logic             done,
  input logic             capturing
);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |=> (storedCount == '0 && !done && !capturing));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !burstStart |=> (storedCount == $past(storedCount) ||
                     storedCount == $past(storedCount) + 1'b1));

  assert_capture_grows_R6: assert property (@(posedge clk) disable iff (!rstN)
    (capturing && cycleValid && !burstStart && !burstEnd)
      |=> storedCount == $past(storedCount) + 1'b1);

  assert_done_freezes_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !burstStart) |=> (done && $stable(storedCount)));

  assert_end_sets_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (burstEnd && !burstStart && capturing) |=> done);

  assert_read_follows_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdReq));

  assert_state_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(done && capturing));

endmodule

bind hist_capture hist_capture_chk #(.CNT_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .burstStart(burstStart), .burstEnd(burstEnd),
  .cycleValid(cycleValid), .rdReq(rdReq), .rdValid(rdValid),
  .storedCount(storedCount), .done(done), .capturing(capturing)
);

// File: tb/hist_capture_tb.sv
module hist_capture_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        burstStart = 1'b0;
  logic        burstEnd = 1'b0;
  logic [1:0]  trigMode = '0;
  logic [31:0] trigCycle = '0;
  logic [7:0]  trigLabel = '0;
  logic [5:0]  cfgCount = '0;
  logic [1:0]  siteSel = '0;
  logic        cycleValid = 1'b0;
  logic [15:0] vecAddr = '0;
  logic [4:0]  tsetIdx = '0;
  logic [7:0]  labelId = '0;
  logic [7:0]  failMask = '0;
  logic        rdReq = 1'b0;
  logic [5:0]  rdAddr = '0;
  logic        rdValid;
  logic [31:0] rdCycle;
  logic [15:0] rdVec;
  logic [4:0]  rdTset;
  logic [7:0]  rdLabel;
  logic [7:0]  rdFail;
  logic [7:0]  rdUnion;
  logic [5:0]  storedCount;
  logic        done;
  logic        capturing;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  hist_capture u_dut (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .burstEnd(burstEnd),
    .trigMode(trigMode), .trigCycle(trigCycle), .trigLabel(trigLabel),
    .cfgCount(cfgCount), .siteSel(siteSel), .cycleValid(cycleValid),
    .vecAddr(vecAddr), .tsetIdx(tsetIdx), .labelId(labelId), .failMask(failMask),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdCycle(rdCycle),
    .rdVec(rdVec), .rdTset(rdTset), .rdLabel(rdLabel), .rdFail(rdFail),
    .rdUnion(rdUnion), .storedCount(storedCount), .done(done), .capturing(capturing)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct {
    longint cyc; int vec; int ts; int lab; int fail; int uni;
  } ent_t;

  ent_t   q[$];
  int     mState = 0;      // 0 idle, 1 armed, 2 recording, 3 finished
  longint mCyc = 0;
  int     mLimit = 0;
  bit     mRdValid = 0;
  ent_t   mRd;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCyc = 0; mLimit = 0; mRdValid = 0; q.delete();
    end else begin
      mRdValid = rdReq && (int'(rdAddr) < q.size());
      if (mRdValid) mRd = q[rdAddr];
      if (burstStart) begin
        int depth;
        depth  = (64 >> siteSel) - 1;
        mLimit = (cfgCount == 0 || int'(cfgCount) > depth) ? depth : int'(cfgCount);
        mState = 1; mCyc = 0; q.delete();
      end else begin
        bit hit;
        bit take;
        case (trigMode)
          2'd0: hit = (failMask != 0);
          2'd1: hit = (mCyc == longint'(trigCycle));
          2'd2: hit = (labelId == trigLabel);
          default: hit = 1;
        endcase
        take = cycleValid && !burstEnd && (mState == 2 || (mState == 1 && hit));
        if (burstEnd && (mState == 1 || mState == 2)) mState = 3;
        else if (take) begin
          ent_t e;
          e.cyc = mCyc; e.vec = vecAddr; e.ts = tsetIdx; e.lab = labelId;
          e.fail = failMask;
          e.uni = (q.size() > 0 && q[$].vec == int'(vecAddr)) ? (q[$].uni | int'(failMask))
                                                               : int'(failMask);
          q.push_back(e);
          mState = (q.size() == mLimit) ? 3 : 2;
        end
        if (cycleValid) mCyc++;
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R7", "done", done, mState == 3);
      chk("R12", "capturing", capturing, mState == 2);
      chk("R6", "storedCount", storedCount, q.size());
      chk("R11", "rdValid", rdValid, mRdValid);
      if (rdValid && mRdValid) begin
        chk("R9", "rdCycle", rdCycle, mRd.cyc);
        chk("R9", "rdVec", rdVec, mRd.vec);
        chk("R9", "rdTset", rdTset, mRd.ts);
        chk("R9", "rdLabel", rdLabel, mRd.lab);
        chk("R9", "rdFail", rdFail, mRd.fail);
        chk("R10", "rdUnion", rdUnion, mRd.uni);
      end
    end
  end

  // ---------------- stimulus tasks (called at a negedge) ----------------
  task automatic startBurst(int mode, int tc, int tl, int cnt, int site);
    trigMode = 2'(mode); trigCycle = 32'(tc); trigLabel = 8'(tl);
    cfgCount = 6'(cnt); siteSel = 2'(site); burstStart = 1'b1;
    @(negedge clk);
    burstStart = 1'b0;
  endtask

  task automatic runCycle(int vec, int lab, int fail);
    cycleValid = 1'b1; vecAddr = 16'(vec); tsetIdx = 5'(vec); labelId = 8'(lab);
    failMask = 8'(fail);
    @(negedge clk);
    cycleValid = 1'b0; failMask = '0; labelId = '0;
  endtask

  task automatic endBurst(bit withCycle);
    burstEnd = 1'b1; cycleValid = withCycle; failMask = 8'hFF;
    @(negedge clk);
    burstEnd = 1'b0; cycleValid = 1'b0; failMask = '0;
  endtask

  task automatic readEntry(int addr);
    rdReq = 1'b1; rdAddr = 6'(addr);
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset capturing", capturing, 0);
    chk("R1", "reset storedCount", storedCount, 0);
    chk("R1", "reset rdValid", rdValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Immediate trigger, 8 sites: depth 64/8-1 = 7
    startBurst(3, 0, 0, 0, 3);
    for (int i = 0; i < 10; i++) runCycle(i, 0, 0);
    chk("R7", "8-site limit", storedCount, 7);
    chk("R7", "done at limit", done, 1);
    readEntry(6);
    chk("R5", "immediate entry6 cycle", rdCycle, 6);
    chk("R9", "entry6 vec", rdVec, 6);

    // First-fail trigger, count 3: entries are cycles 4,5,6
    startBurst(0, 0, 0, 3, 0);
    chk("R2", "start clears count", storedCount, 0);
    chk("R2", "start clears done", done, 0);
    for (int i = 0; i < 8; i++) runCycle(20 + i, 0, (i >= 4) ? i : 0);
    chk("R7", "cfgCount limit", storedCount, 3);
    readEntry(0);
    chk("R3", "first fail cycle", rdCycle, 4);
    chk("R9", "first fail mask", rdFail, 4);

    // Cycle-number trigger 5 with idle gaps, end presented with a valid cycle
    startBurst(1, 5, 0, 0, 2);
    for (int i = 0; i < 8; i++) begin
      runCycle(40 + i, 0, 0);
      @(negedge clk);
    end
    endBurst(1'b1);
    chk("R8", "end stops capture", storedCount, 3);
    chk("R8", "end sets done", done, 1);
    runCycle(99, 0, 1);
    chk("R8", "no store after end", storedCount, 3);
    readEntry(0);
    chk("R4", "cycle trigger entry0", rdCycle, 5);
    readEntry(2);
    chk("R6", "gapped entry2 cycle", rdCycle, 7);

    // Label trigger and fail union over a repeated vector
    startBurst(2, 0, 8'hA5, 0, 0);
    runCycle(1, 0, 0); runCycle(2, 0, 0); runCycle(3, 0, 0);
    runCycle(10, 8'hA5, 1); runCycle(10, 0, 2); runCycle(10, 0, 4); runCycle(11, 0, 8);
    chk("R5", "label trigger count", storedCount, 4);
    readEntry(0);
    chk("R5", "label entry cycle", rdCycle, 3);
    chk("R9", "label entry label", rdLabel, 8'hA5);
    readEntry(2);
    chk("R10", "union over run", rdUnion, 7);
    readEntry(3);
    chk("R10", "union restarts", rdUnion, 8);
    readEntry(4);
    chk("R11", "read at count invalid", rdValid, 0);
    readEntry(20);
    chk("R11", "read far out invalid", rdValid, 0);

    // Count above depth with 2 sites: limit 31
    startBurst(3, 0, 0, 40, 1);
    runCycle(0, 0, 0);
    chk("R12", "capturing after trigger", capturing, 1);
    for (int i = 1; i < 35; i++) runCycle(i, 0, i & 3);
    chk("R7", "2-site limit", storedCount, 31);
    chk("R12", "capturing off at done", capturing, 0);

    // First-fail trigger with no failure
    startBurst(0, 0, 0, 0, 3);
    for (int i = 0; i < 5; i++) runCycle(i, 0, 0);
    chk("R3", "no fail no record", storedCount, 0);
    chk("R12", "armed not capturing", capturing, 0);
    endBurst(1'b0);
    chk("R8", "end while armed", done, 1);
    chk("R3", "still empty", storedCount, 0);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule